// File: doc/BRIEF.md
# Tuning Synthesizer Digital Core

This block holds the clocked part of a frequency synthesizer inside a radio tuning controller. A reference divider counts ticks of a 75 kHz crystal and makes one of seven loop reference rates. A local oscillator divider counts pulses from one of two digitised oscillator inputs and makes a divided event. On the upper band the divider uses a fixed halving stage and a 16/17 pulse-swallow prescaler. On the lower band the oscillator feeds the programmable counter directly. A three-state phase-frequency detector compares the two event streams and drives a charge pump code. It also keeps a sticky unlock flag that the controller can clear.

All logic runs on one fast system clock. The crystal tick and the oscillator inputs arrive as single-cycle strobes on that clock. When the enable input is low the block is stopped. This stop state stands for reset, halt, backup and loop-stop alike: the charge pump code goes idle and every counter is cleared.

Top module: `pll_synth_core`

## Requirements
- R1: While `enable_i` is low, or during reset, `cp_o` is 2'b00 (high impedance) from the first clock edge on. Tick and oscillator strobes have no effect, and `unlock_o` keeps its value.
- R2: The reference event occurs once every K counted ticks. K is 75, 25, 24, 15, 12, 6 for `ref_sel_i` codes 0 to 5, and 3 for codes 6 and 7.
- R3: With `band_fm_i`=0, the divided event occurs once every N pulses on `lo_am_i`, where N is `ratio_i` (N of at least 2). `lo_fm_i` is ignored.
- R4: With `band_fm_i`=1, the divided event occurs once every 2*(16*M+S) pulses on `lo_fm_i`, where M is `ratio_i[11:4]` and S is `ratio_i[3:0]`. M must be at least 1 and at least S. `lo_am_i` is ignored.
- R5: A divided event that leads turns `cp_o` to 2'b01 (drive high). A reference event that leads turns it to 2'b10 (drive low). The pulse ends when the lagging event arrives. A strobe that completes a count changes `cp_o` two clock edges later.
- R6: With `dz_wide_i`=1, the first DZ_WIDE (3) cycles of every pulse show as 2'b00. With `dz_wide_i`=0, the whole pulse is shown.
- R7: `unlock_o` is set one edge after a running pulse has lasted ULK_CYC+1 (7) cycles, and it stays set.
- R8: A one-cycle `unlock_clr_i` clears `unlock_o`. A set in the same cycle wins.
- R9: A new ratio or band takes effect only at the divider's terminal count. A new reference select takes effect only when the reference count wraps. Both load freely while stopped.
- R10: A repeated leading event holds the current pulse. Events of both kinds in the same cycle produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run when high, stopped when low |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal period |
| lo_fm_i | input | 1 | Upper-band oscillator pulse strobe |
| lo_am_i | input | 1 | Lower-band oscillator pulse strobe |
| band_fm_i | input | 1 | 1 selects upper band path |
| ratio_i | input | 12 | Programmable divide ratio |
| ref_sel_i | input | 3 | Reference rate select |
| dz_wide_i | input | 1 | 1 selects the wide dead zone |
| unlock_clr_i | input | 1 | Clear pulse for the unlock flag |
| cp_o | output | 2 | Charge pump code: 00 off, 01 high, 10 low |
| unlock_o | output | 1 | Sticky unlock flag |

## Verification
Every event reaches `cp_o` two edges after the strobe that completes its count. The first edge registers the divider event and the second updates the detector state. `unlock_o` follows one edge after a pulse reaches its age limit. The bench drives inputs at the falling edge and keeps the event flags it derives from its own strobe counts in a two-deep delay line. At each falling edge it advances its detector model and compares both outputs in exactly the cycle each result is due. Configuration changes are made only while stopped, or are timed against the bench's own count of the terminal event.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;
  localparam int REF_W = 7;
  localparam int SEL_W = 3;
  localparam logic [1:0] CP_OFF = 2'b00;
  localparam logic [1:0] CP_HI  = 2'b01;
  localparam logic [1:0] CP_LO  = 2'b10;

  function automatic logic [REF_W-1:0] ref_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return REF_W'(75);
      3'd1:    return REF_W'(25);
      3'd2:    return REF_W'(24);
      3'd3:    return REF_W'(15);
      3'd4:    return REF_W'(12);
      3'd5:    return REF_W'(6);
      default: return REF_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
  import pll_synth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  logic [SEL_W-1:0] sel_q;
  logic [REF_W-1:0] cnt_q, lim;

  assign lim = ref_ratio(sel_q) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else if (!en_i) begin
      sel_q <= sel_i;
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == lim) begin
          cnt_q <= '0;
          evt_o <= 1'b1;
          sel_q <= sel_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2
  ref_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/pll_lo_div.sv
module pll_lo_div #(
  parameter int RATIO_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               band_fm_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               fm_i,
  input  logic               am_i,
  output logic               evt_o
);
  localparam int MW = RATIO_W - 4;

  logic               band_q, pre_q;
  logic [RATIO_W-1:0] ratio_q, am_q;
  logic [MW-1:0]      mc_q, m_v;
  logic [3:0]         s_v;
  logic [4:0]         ps_q, ps_lim;
  logic               strobe, swallow, ps_en, ps_wrap, term_fm, term_am, term;

  assign m_v     = ratio_q[RATIO_W-1:4];
  assign s_v     = ratio_q[3:0];
  assign strobe  = band_q ? fm_i : am_i;
  assign swallow = mc_q < MW'(s_v);
  assign ps_lim  = swallow ? 5'd16 : 5'd15;
  assign ps_en   = band_q && strobe && pre_q;
  assign ps_wrap = ps_en && (ps_q == ps_lim);
  assign term_fm = ps_wrap && (mc_q == m_v - 1'b1);
  assign term_am = !band_q && strobe && (am_q == ratio_q - 1'b1);
  assign term    = term_fm || term_am;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q  <= 1'b0;
      ratio_q <= RATIO_W'(2);
      pre_q   <= 1'b0;
      ps_q    <= '0;
      mc_q    <= '0;
      am_q    <= '0;
      evt_o   <= 1'b0;
    end else if (!en_i) begin
      band_q  <= band_fm_i;
      ratio_q <= ratio_i;
      pre_q   <= 1'b0;
      ps_q    <= '0;
      mc_q    <= '0;
      am_q    <= '0;
      evt_o   <= 1'b0;
    end else begin
      evt_o <= term;
      if (band_q && strobe) pre_q <= ~pre_q;
      if (ps_en)   ps_q <= ps_wrap ? '0 : ps_q + 1'b1;
      if (ps_wrap) mc_q <= term_fm ? '0 : mc_q + 1'b1;
      if (!band_q && strobe) am_q <= term_am ? '0 : am_q + 1'b1;
      if (term) begin
        band_q  <= band_fm_i;
        ratio_q <= ratio_i;
      end
    end
  end

  // R9
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !term |=> $stable(ratio_q) && $stable(band_q));
  // R3
  am_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !band_q && ratio_q >= RATIO_W'(2) |-> am_q < ratio_q);
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
  import pll_synth_pkg::*;
#(
  parameter int DZ_WIDE = 3,
  parameter int ULK_CYC = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       ref_evt_i,
  input  logic       div_evt_i,
  input  logic       dz_wide_i,
  input  logic       unlock_clr_i,
  output logic [1:0] cp_o,
  output logic       unlock_o
);
  localparam int AGE_W = $clog2(ULK_CYC + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ULK_CYC + 1);
  localparam logic [AGE_W-1:0] ULK_AGE = AGE_W'(ULK_CYC);
  localparam logic [AGE_W-1:0] DZ_AGE  = AGE_W'(DZ_WIDE);

  logic             up_q, dn_q, unlock_q;
  logic [AGE_W-1:0] age_q, thr;
  logic             nu, nd, kill, up_d, dn_d, ulk_set;

  assign nu      = up_q || div_evt_i;
  assign nd      = dn_q || ref_evt_i;
  assign kill    = nu && nd;
  assign up_d    = nu && !kill;
  assign dn_d    = nd && !kill;
  assign ulk_set = en_i && (up_q || dn_q) && (age_q == ULK_AGE);
  assign thr     = dz_wide_i ? DZ_AGE : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      age_q <= '0;
    end else if (!en_i) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      age_q <= '0;
    end else begin
      up_q  <= up_d;
      dn_q  <= dn_d;
      if ((up_d || dn_d) && (up_q || dn_q))
        age_q <= (age_q == AGE_MAX) ? age_q : age_q + 1'b1;
      else
        age_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unlock_q <= 1'b0;
    else         unlock_q <= ulk_set || (unlock_q && !unlock_clr_i);
  end

  assign unlock_o = unlock_q;
  assign cp_o = (up_q && age_q >= thr) ? CP_HI :
                (dn_q && age_q >= thr) ? CP_LO : CP_OFF;

  // R5
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_q, dn_q}));
  // R10
  pair_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && ref_evt_i |=> !up_q && !dn_q);
  // R7
  unl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_q && !unlock_clr_i |=> unlock_q);
  // R7
  unl_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_q) |-> $past(up_q || dn_q));
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_synth_pkg::*;
#(
  parameter int RATIO_W = 12,
  parameter int DZ_WIDE = 3,
  parameter int ULK_CYC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               xtal_tick_i,
  input  logic               lo_fm_i,
  input  logic               lo_am_i,
  input  logic               band_fm_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [SEL_W-1:0]   ref_sel_i,
  input  logic               dz_wide_i,
  input  logic               unlock_clr_i,
  output logic [1:0]         cp_o,
  output logic               unlock_o
);
  logic ref_evt, div_evt;

  pll_ref_div u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i),
    .tick_i (xtal_tick_i),
    .sel_i  (ref_sel_i),
    .evt_o  (ref_evt)
  );

  pll_lo_div #(.RATIO_W(RATIO_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .band_fm_i (band_fm_i),
    .ratio_i   (ratio_i),
    .fm_i      (lo_fm_i),
    .am_i      (lo_am_i),
    .evt_o     (div_evt)
  );

  pll_pfd #(.DZ_WIDE(DZ_WIDE), .ULK_CYC(ULK_CYC)) u_pfd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (enable_i),
    .ref_evt_i    (ref_evt),
    .div_evt_i    (div_evt),
    .dz_wide_i    (dz_wide_i),
    .unlock_clr_i (unlock_clr_i),
    .cp_o         (cp_o),
    .unlock_o     (unlock_o)
  );

  // R1
  stop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> cp_o == CP_OFF);
endmodule

// File: tb/sim_pll_synth_core.sv
module sim_pll_synth_core;
  localparam int RW  = 12;
  localparam int DZW = 3;
  localparam int ULK = 6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0;
  logic lo_fm = 1'b0, lo_am = 1'b0, band = 1'b0, dzw = 1'b0, clr = 1'b0;
  logic [RW-1:0] ratio = RW'(10);
  logic [2:0] sel = 3'd6;
  logic [1:0] cp;
  logic unl;

  always #4 clk = ~clk;

  pll_synth_core #(.RATIO_W(RW), .DZ_WIDE(DZW), .ULK_CYC(ULK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .xtal_tick_i(tick),
    .lo_fm_i(lo_fm), .lo_am_i(lo_am), .band_fm_i(band), .ratio_i(ratio),
    .ref_sel_i(sel), .dz_wide_i(dzw), .unlock_clr_i(clr),
    .cp_o(cp), .unlock_o(unl)
  );

  int errors = 0, checks = 0;
  int t_per = 40, t_ph = 0, l_per = 12, l_ph = 0;
  bit cfg_en = 0, cfg_clr = 0;
  int c = 0, g = 0, tc = 0, lc = 0, rt = 3, lt = 10;
  bit rf1 = 0, rf2 = 0, df1 = 0, df2 = 0, en_k = 0, clr_k = 0;
  int s = 0, age = 0;
  bit m_unl = 0;
  int cp_bad = 0, unl_bad = 0, act = 0;

  function automatic int refr(int k);
    case (k)
      0: return 75; 1: return 25; 2: return 24; 3: return 15;
      4: return 12; 5: return 6; default: return 3;
    endcase
  endfunction

  function automatic int units(bit b, int r);
    return b ? 2 * (16 * (r / 16) + r % 16) : r;
  endfunction

  task automatic chk(bit ok, string tag, int a, int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic step();
    int thr, ecp, ns;
    bit set, tk, sb, rn, dn;
    @(negedge clk);
    set = en_k && s != 0 && age == ULK;
    m_unl = set ? 1'b1 : (clr_k ? 1'b0 : m_unl);
    if (!en_k) begin
      s = 0; age = 0;
    end else begin
      ns = s;
      if ((s == 1 && rf2) || (s == -1 && df2) || (s == 0 && rf2 && df2)) ns = 0;
      else if (df2) ns = 1;
      else if (rf2) ns = -1;
      if (ns != 0 && s != 0) age++; else age = 0;
      s = ns;
    end
    thr = dzw ? DZW : 0;
    ecp = (s == 1 && age >= thr) ? 1 : (s == -1 && age >= thr) ? 2 : 0;
    if (int'(cp) != ecp) cp_bad++;
    if (unl != m_unl) unl_bad++;
    if (cp != 2'b00) act++;
    tk = ((cfg_en ? c : g) % t_per) == t_ph;
    sb = ((cfg_en ? c : g) % l_per) == l_ph;
    rn = 0; dn = 0;
    if (cfg_en) begin
      if (tk) begin
        tc++;
        if (tc == rt) begin rn = 1; tc = 0; rt = refr(int'(sel)); end
      end
      if (sb) begin
        lc++;
        if (lc == lt) begin dn = 1; lc = 0; lt = units(band, int'(ratio)); end
      end
      c++;
    end else begin
      tc = 0; lc = 0; c = 0;
      rt = refr(int'(sel)); lt = units(band, int'(ratio));
    end
    g++;
    en    = cfg_en;
    tick  = tk;
    lo_fm = band ? sb : (g % 3 == 0);
    lo_am = band ? (g % 5 == 0) : sb;
    clr   = cfg_clr;
    rf2 = rf1; df2 = df1; rf1 = rn; df1 = dn;
    en_k = cfg_en; clr_k = cfg_clr;
  endtask

  task automatic setup(bit b, int r, int sl, bit dz, int tp, int tph, int lp, int lph);
    cfg_en = 0;
    band = b; ratio = RW'(r); sel = 3'(sl); dzw = dz;
    t_per = tp; t_ph = tph; l_per = lp; l_ph = lph;
    repeat (4) step();
    cfg_en = 1;
  endtask

  task automatic run(int n);
    cp_bad = 0; unl_bad = 0; act = 0;
    repeat (n) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cp == 2'b00, "R1 reset cp", int'(cp), 0);
    chk(unl == 1'b0, "R1 reset unlock", int'(unl), 0);
    rst_n = 1'b1;

    // R3 R5: lower band, divided edge leads by 2
    setup(0, 10, 6, 0, 40, 30, 12, 0);
    run(1200);
    chk(cp_bad == 0, "R5 cp timing lower band", cp_bad, 0);
    chk(act > 0, "R3 pulses present", act, 1);
    chk(unl_bad == 0, "R7 unlock model", unl_bad, 0);

    // R6: wide dead zone, lead of 5
    setup(0, 10, 6, 1, 40, 33, 12, 0);
    run(1200);
    chk(cp_bad == 0, "R6 dead zone cp", cp_bad, 0);
    chk(act > 0, "R6 residual pulse", act, 1);

    // R4: upper band, locked ratio 0x21
    setup(1, 'h21, 6, 0, 44, 40, 2, 0);
    run(2000);
    chk(cp_bad == 0, "R4 cp upper band", cp_bad, 0);
    chk(act > 0, "R4 pulses present", act, 1);
    chk(unl == 1'b0, "R4 stays locked", int'(unl), 0);

    // R7 R10: upper band divided too fast
    setup(1, 'h20, 6, 0, 44, 40, 2, 0);
    run(2000);
    chk(cp_bad == 0, "R10 repeated lead cp", cp_bad, 0);
    chk(unl_bad == 0, "R7 unlock timing", unl_bad, 0);
    chk(unl == 1'b1, "R7 unlock set", int'(unl), 1);

    // R1: stopped, strobes ignored, flag kept
    cfg_en = 0;
    run(300);
    chk(cp_bad == 0 && act == 0, "R1 stopped cp", act, 0);
    chk(unl == 1'b1, "R1 flag retained", int'(unl), 1);

    // R8: clear
    cfg_clr = 1; step(); cfg_clr = 0;
    run(5);
    chk(unl == 1'b0, "R8 unlock cleared", int'(unl), 0);
    chk(unl_bad == 0, "R8 clear timing", unl_bad, 0);

    // R9: ratio change while running
    setup(0, 10, 6, 0, 40, 30, 12, 0);
    run(600);
    ratio = RW'(5);
    run(600);
    chk(cp_bad == 0, "R9 ratio at terminal count", cp_bad, 0);
    chk(unl_bad == 0, "R9 unlock model", unl_bad, 0);

    // R2: sweep of reference selects
    for (int k = 0; k < 8; k++) begin
      setup(0, refr(k), k, 0, 4, 0, 4, 1);
      run(700);
      chk(cp_bad == 0, "R2 reference ratio cp", cp_bad, 0);
      chk(act > 0, "R2 pulses present", act, 1);
    end

    // R10: coincident events
    setup(0, 10, 6, 0, 40, 28, 12, 0);
    run(1200);
    chk(act == 0, "R10 coincident no pulse", act, 0);
    chk(cp_bad == 0, "R10 coincident cp", cp_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule